// File: doc/BRIEF.md
# Sine-Table PWM Generator with Period-Aligned Duty Update

This block drives a single-bit pulse-width-modulated output. Its duty cycle follows one stored cycle of a sine wave, and the block presents one sample per PWM period. An analog low-pass filter outside the block smooths the pulse train into a sinusoid. A prescaler divides the input clock into count steps. A modulo counter splits those steps into PWM periods. A fixed sample table supplies the duty values, and an index register walks through the table once per period.

The next duty value is fetched into a shadow register while the current period runs. It is copied into the active compare register only on the clock edge where the counter rolls over. A duty change therefore never lands mid-period. This removes the case where the counter has already passed a newly written smaller compare value, no match occurs, and the pin stays high through the period boundary.

After reset the output stays low for one dark period that holds table entry 0. Period k after reset then uses entry k mod TABLE_LEN.

Top module: `sine_pwm_gen`

## Requirements
- R1: The period counter steps once every PRESC_DIV clocks (default 64). It runs from 0 to MODULO (default 350) and then returns to 0, so every PWM period lasts exactly (MODULO+1)*PRESC_DIV clocks while `en` is high.
- R2: `period_start` is high for exactly one clock, the first clock of each PWM period, which is the clock just after the counter rolls over to 0.
- R3: In each period, `pwm_out` (active high) is high from the first clock of the period for exactly D*PRESC_DIV clocks, where D is that period's duty entry. It is then low until the next period starts, so there is one pulse per period at most.
- R4: Table entry i equals 125 + round(125*sin(2*pi*i/100)) for the default 100 entries and amplitude 250. Rounding is half away from zero. In particular, entry 0 = 125, entry 25 = 250, entry 50 = 125 and entry 75 = 0, with entry 1 = 133 and entry 99 = 117.
- R5: Period k after reset (k >= 1) uses entry k mod 100. The index wraps from 99 to 0, so all 100 entries are used in turn.
- R6: The active compare value changes only at a counter rollover. A pulse that has started always ends inside its own period and never runs across a period boundary.
- R7: A period whose duty entry is 0 keeps `pwm_out` low for the whole period, with no rising edge.
- R8: While `rst` is high, `pwm_out` and `period_start` are low. After `rst` falls, `pwm_out` stays low through the first (MODULO+1)*PRESC_DIV-clock period, and the first `period_start` appears on clock (MODULO+1)*PRESC_DIV.
- R9: While `en` is low, the prescaler and the counter hold, `pwm_out` keeps its level and no `period_start` is produced. The current period is stretched by exactly the number of disabled clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes the generator |
| pwm_out | output | 1 | PWM output, active high |
| period_start | output | 1 | One-clock strobe on the first clock of each PWM period |

## Verification
The assertions check the following on every cycle:
- The counter stays inside its range.
- The strobe lasts one clock.
- The output rises only together with the strobe.
- The output falls only when the count equals the active compare value.
- The compare value is frozen between rollovers.
- The index wraps from its last entry to 0.
- A disabled clock moves nothing.

Only the bench's scenarios can show the following:
- The exact duty of each period against an independently computed sine.
- The order in which entries are consumed across the wrap.
- The dark first period after reset.
- The exact stretch of a period caused by a freeze.

// File: rtl/sine_pwm_pkg.sv
package sine_pwm_pkg;

    localparam int DEF_PRESC_DIV = 64;
    localparam int DEF_MODULO    = 350;
    localparam int DEF_TABLE_LEN = 100;
    localparam int DEF_AMPLITUDE = 250;

    // Fixed-point format used only at elaboration time to build the table
    localparam int    FX_BITS = 28;
    localparam longint PI_FX  = 64'sd843314857;  // pi * 2^28, rounded

    // Action taken on the PWM output register in a given clock
    typedef enum logic [1:0] {
        PWM_HOLD = 2'd0,
        PWM_RISE = 2'd1,
        PWM_FALL = 2'd2,
        PWM_DARK = 2'd3
    } pwm_action_t;

    // Sample idx of one sine cycle spread over n entries, offset to amp/2,
    // peak-to-peak amp, rounded half away from zero. Integer-only so the
    // table folds to constants.
    function automatic int sine_sample(input int idx, input int n, input int amp);
        longint ang;
        longint term;
        longint acc;
        longint half;
        longint mag;
        logic   neg;
        ang = (2 * PI_FX * longint'(idx)) / longint'(n);
        neg = 1'b0;
        if (ang > PI_FX) begin
            ang = ang - PI_FX;
            neg = 1'b1;
        end
        if (ang > PI_FX / 2) begin
            ang = PI_FX - ang;
        end
        acc  = ang;
        term = ang;
        for (int k = 1; k <= 7; k++) begin
            term = -((((term * ang) >>> FX_BITS) * ang) >>> FX_BITS)
                   / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        half = longint'(amp / 2);
        mag  = (half * acc + (64'sd1 <<< (FX_BITS - 1))) >>> FX_BITS;
        return neg ? int'(half - mag) : int'(half + mag);
    endfunction

endpackage

// File: rtl/sine_pwm_prescaler.sv
module sine_pwm_prescaler #(
    parameter int DIV = sine_pwm_pkg::DEF_PRESC_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_bypass
            assign tick = en;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    div_q <= '0;
                end else if (en) begin
                    div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
                end
            end

            assign tick = en && (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/sine_pwm_period_ctr.sv
module sine_pwm_period_ctr #(
    parameter int MODULO = sine_pwm_pkg::DEF_MODULO,
    parameter int CW     = $clog2(MODULO + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [CW-1:0] cnt_q,
    output logic          wrap
);
    localparam logic [CW-1:0] TOP = CW'(MODULO);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
        end
    end

    // Rollover happens on the step that leaves the top count
    assign wrap = tick && (cnt_q == TOP);
endmodule

// File: rtl/sine_pwm_rom.sv
module sine_pwm_rom #(
    parameter int N   = sine_pwm_pkg::DEF_TABLE_LEN,
    parameter int AMP = sine_pwm_pkg::DEF_AMPLITUDE,
    parameter int SW  = $clog2(AMP + 1),
    parameter int IW  = $clog2(N)
) (
    input  logic [IW-1:0] idx,
    output logic [SW-1:0] sample
);
    logic [SW-1:0] tbl [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_entry
            assign tbl[i] = SW'(sine_pwm_pkg::sine_sample(i, N, AMP));
        end
    endgenerate

    assign sample = tbl[idx];
endmodule

// File: rtl/sine_pwm_duty_ctl.sv
module sine_pwm_duty_ctl
    import sine_pwm_pkg::*;
#(
    parameter int N   = DEF_TABLE_LEN,
    parameter int AMP = DEF_AMPLITUDE,
    parameter int CW  = $clog2(DEF_MODULO + 1),
    parameter int SW  = $clog2(AMP + 1),
    parameter int IW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          wrap,
    input  logic [CW-1:0] cnt_q,
    input  logic [SW-1:0] rom_sample,
    output logic [IW-1:0] idx_nxt,
    output logic [IW-1:0] idx_q,
    output logic [CW-1:0] active_q,
    output logic          pwm_q
);
    localparam logic [IW-1:0] IDX_LAST = IW'(N - 1);
    localparam logic [CW-1:0] FIRST    = CW'(sine_sample(0, N, AMP));

    logic [SW-1:0] shadow_q;
    logic [CW-1:0] cnt_step;
    pwm_action_t   action;

    assign idx_nxt  = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    assign cnt_step = cnt_q + 1'b1;

    // Shadow follows the entry for the coming period throughout the period
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else begin
            shadow_q <= rom_sample;
        end
    end

    // Active compare and index move only at rollover
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= FIRST;
            idx_q    <= '0;
        end else if (wrap) begin
            active_q <= CW'(shadow_q);
            idx_q    <= idx_nxt;
        end
    end

    always_comb begin
        action = PWM_HOLD;
        if (wrap) begin
            action = (shadow_q == '0) ? PWM_DARK : PWM_RISE;
        end else if (step && pwm_q && (cnt_step == active_q)) begin
            action = PWM_FALL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q <= 1'b0;
        end else begin
            case (action)
                PWM_RISE: pwm_q <= 1'b1;
                PWM_FALL: pwm_q <= 1'b0;
                PWM_DARK: pwm_q <= 1'b0;
                default:  pwm_q <= pwm_q;
            endcase
        end
    end
endmodule

// File: rtl/sine_pwm_gen.sv
module sine_pwm_gen
    import sine_pwm_pkg::*;
#(
    parameter int PRESC_DIV = DEF_PRESC_DIV,
    parameter int MODULO    = DEF_MODULO,
    parameter int TABLE_LEN = DEF_TABLE_LEN,
    parameter int AMPLITUDE = DEF_AMPLITUDE
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic pwm_out,
    output logic period_start
);
    localparam int CW = $clog2(MODULO + 1);
    localparam int SW = $clog2(AMPLITUDE + 1);
    localparam int IW = $clog2(TABLE_LEN);

    logic          tick;
    logic          wrap;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] active_cmp;
    logic [IW-1:0] tbl_idx;
    logic [IW-1:0] tbl_idx_nxt;
    logic [SW-1:0] tbl_sample;
    logic          strobe_q;

    sine_pwm_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (tick)
    );

    sine_pwm_period_ctr #(.MODULO(MODULO), .CW(CW)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cnt_q (cnt_q),
        .wrap  (wrap)
    );

    sine_pwm_rom #(.N(TABLE_LEN), .AMP(AMPLITUDE), .SW(SW), .IW(IW)) u_rom (
        .idx    (tbl_idx_nxt),
        .sample (tbl_sample)
    );

    sine_pwm_duty_ctl #(
        .N(TABLE_LEN), .AMP(AMPLITUDE), .CW(CW), .SW(SW), .IW(IW)
    ) u_duty (
        .clk        (clk),
        .rst        (rst),
        .step       (tick),
        .wrap       (wrap),
        .cnt_q      (cnt_q),
        .rom_sample (tbl_sample),
        .idx_nxt    (tbl_idx_nxt),
        .idx_q      (tbl_idx),
        .active_q   (active_cmp),
        .pwm_q      (pwm_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= wrap;
        end
    end

    assign period_start = strobe_q;
endmodule

// File: rtl/sine_pwm_gen_chk.sv
module sine_pwm_gen_chk #(
    parameter int MODULO    = 350,
    parameter int TABLE_LEN = 100,
    parameter int CW        = 9,
    parameter int IW        = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          pwm_out,
    input logic          period_start,
    input logic          wrap,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] active,
    input logic [IW-1:0] idx
);
    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MODULO));

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        period_start |=> !period_start);

    // R3
    fall_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm_out) |-> (cnt == active));

    // R6
    rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> period_start);

    // R6
    cmp_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(active));

    // R5
    idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && (idx == IW'(TABLE_LEN - 1))) |=> (idx == '0));

    // R5
    idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx <= IW'(TABLE_LEN - 1));

    // R7
    dark_period_chk: assert property (@(posedge clk) disable iff (rst)
        (period_start && (active == '0)) |-> !pwm_out);

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!period_start && $stable(pwm_out)));
endmodule

bind sine_pwm_gen sine_pwm_gen_chk #(
    .MODULO(MODULO), .TABLE_LEN(TABLE_LEN), .CW(CW), .IW(IW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .pwm_out      (pwm_out),
    .period_start (period_start),
    .wrap         (wrap),
    .cnt          (cnt_q),
    .active       (active_cmp),
    .idx          (tbl_idx)
);

// File: tb/sim_sine_pwm_gen.sv
module sim_sine_pwm_gen;
    localparam int DIV  = 2;
    localparam int MOD  = 350;
    localparam int PER  = (MOD + 1) * DIV;
    localparam int NPER = 102;
    localparam int NVEC = 6;
    // {period number, expected duty entry}
    localparam int VEC [NVEC][2] = '{
        '{25, 250}, '{50, 125}, '{75, 0}, '{99, 117}, '{100, 125}, '{101, 133}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic pwm_out;
    logic period_start;

    int n_chk  = 0;
    int n_fail = 0;
    int hi_arr [NPER + 1];

    always #10 clk = ~clk;

    sine_pwm_gen #(.PRESC_DIV(DIV), .MODULO(MOD)) u0 (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .pwm_out      (pwm_out),
        .period_start (period_start)
    );

    function automatic int model(input int i);
        real v;
        v = 125.0 * $sin(6.283185307179586 * real'(i) / 100.0);
        if (v >= 0.0) return 125 + int'($floor(v + 0.5));
        return 125 - int'($floor(-v + 0.5));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called on the sample where period_start is high; returns on the
    // sample where the next period_start rises.
    task automatic measure(input int frz_at, input int frz_len,
                           output int hi, output int len, output int ps_cnt,
                           output int rises, output bit frz_ok);
        logic prev_pwm;
        logic prev_ps;
        logic fv;
        len = 1; hi = int'(pwm_out); ps_cnt = 1; rises = 0; frz_ok = 1'b1;
        prev_pwm = pwm_out; prev_ps = 1'b1; fv = pwm_out;
        forever begin
            if (frz_len > 0 && len == frz_at) begin
                en = 1'b0;
                fv = pwm_out;
            end
            if (frz_len > 0 && len == frz_at + frz_len) en = 1'b1;
            @(negedge clk);
            if (period_start && !prev_ps) break;
            if (len > 4 * PER) break;
            len++;
            hi += int'(pwm_out);
            ps_cnt += int'(period_start);
            if (pwm_out && !prev_pwm) rises++;
            if (frz_len > 0 && len > frz_at && len <= frz_at + frz_len
                && pwm_out != fv) frz_ok = 1'b0;
            prev_pwm = pwm_out;
            prev_ps  = period_start;
        end
    endtask

    task automatic wait_first(output int n, output int dark_hi);
        n = 0; dark_hi = 0;
        forever begin
            @(negedge clk);
            n++;
            if (period_start || n > 4 * PER) break;
            dark_hi += int'(pwm_out);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, dark, hi, len, psc, rises;
        bit fok;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(pwm_out == 1'b0, "R8 pwm in reset", int'(pwm_out), 0);
        check(period_start == 1'b0, "R8 strobe in reset", int'(period_start), 0);
        rst = 1'b0;

        wait_first(n, dark);
        check(n == PER, "R8 first strobe clock", n, PER);
        check(dark == 0, "R8 dark first period", dark, 0);

        for (int p = 1; p <= NPER; p++) begin
            measure(0, 0, hi, len, psc, rises, fok);
            hi_arr[p] = hi;
            check(len == PER, "R1 period length", len, PER);
            check(psc == 1, "R2 strobe width", psc, 1);
            check(hi == model(p % 100) * DIV, "R3 R5 high time", hi, model(p % 100) * DIV);
            check(rises == 0, "R6 single pulse", rises, 0);
            if (p % 100 == 75) check(hi == 0, "R7 zero duty", hi, 0);
        end

        for (int v = 0; v < NVEC; v++) begin
            check(hi_arr[VEC[v][0]] == VEC[v][1] * DIV, "R4 table entry",
                  hi_arr[VEC[v][0]], VEC[v][1] * DIV);
        end

        // Period 103 (entry 3): freeze 50 clocks inside the high phase
        measure(20, 50, hi, len, psc, rises, fok);
        check(len == PER + 50, "R9 stretched length", len, PER + 50);
        check(hi == model(3) * DIV + 50, "R9 stretched high", hi, model(3) * DIV + 50);
        check(fok, "R9 output held", int'(fok), 1);
        check(psc == 1, "R9 no strobe while frozen", psc, 1);

        // Reset in the middle of period 104
        repeat (100) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R8 pwm after mid reset", int'(pwm_out), 0);
        check(period_start == 1'b0, "R8 strobe after mid reset", int'(period_start), 0);
        rst = 1'b0;
        wait_first(n, dark);
        check(n == PER, "R8 restart strobe clock", n, PER);
        check(dark == 0, "R8 restart dark period", dark, 0);
        measure(0, 0, hi, len, psc, rises, fok);
        check(hi == model(1) * DIV, "R5 restart entry", hi, model(1) * DIV);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule